// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a master-side engine that returns a two-wire bus to a known protocol state after a power loss, a system reset or a transfer that was cut off part way. A one-cycle request starts a fixed pattern on the clock and data lines:

- a start condition;
- nine dummy clock cycles with the data line released;
- a second start;
- a stop.

Any target that was left part way through a byte sees the pattern as a new frame, which it then abandons.

The block drives both lines as open-drain enables. Each phase lasts a programmable number of system clock cycles: the clock low time, the clock high time, the edge setup and hold time, and the bus-free time. A system integrator chooses these counts so that the bus minimums are met at the system clock rate. The block shows `busy` for the whole pattern and raises `done` for one cycle once the bus-free gap has passed. It does not carry data, stretch the clock or arbitrate.

Top module: `twi_recover`

## Requirements
- R1: After reset both pull enables are 0, which means the line is released. `busy` and `done` are also 0.
- R2: A `start_req` seen high at a clock edge while idle makes `busy` 1 from the next cycle. `busy` stays 1 for exactly 5·E + 9·(L+H) + F cycles. Here E, L, H and F are the edge, low, high and free counts after the rule in R7.
- R3: The first start works as follows. Both lines are released for E cycles. Then `sda_pull`=1 (data driven low) while `scl_pull`=0 for E cycles. Then both are 1 for E cycles, which is the data hold after the start.
- R4: The block then gives nine clock cycles. In each, `scl_pull`=1 for L cycles and then `scl_pull`=0 for H cycles, with `sda_pull`=0 throughout. This gives exactly nine releases of the clock line.
- R5: After the ninth high phase, both lines stay released for E more cycles. Then `sda_pull`=1 with `scl_pull`=0 for E cycles, which is the second start. Then `sda_pull` returns to 0 while the clock is still released, which is the stop. One pattern therefore shows exactly two starts and one stop.
- R6: After the stop, both lines stay released for F cycles. `done` is 1 for exactly the one cycle in which `busy` first reads 0.
- R7: A count of 0 acts as 1.
- R8: A `start_req` that arrives while `busy` is 1 has no effect on the lines, on `busy` or on `done`.
- R9: `sda_pull` never changes in a cycle in which `scl_pull` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to run the recovery pattern |
| cnt_low | input | CW | Clock-low phase length in cycles |
| cnt_high | input | CW | Clock-high phase length in cycles |
| cnt_edge | input | CW | Start setup, start hold, data hold and stop setup length |
| cnt_free | input | CW | Bus-free length after the stop |
| scl_pull | output | 1 | 1 drives the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 drives the data line low, 0 releases it |
| busy | output | 1 | Pattern in progress |
| done | output | 1 | One-cycle pulse at the end of the bus-free gap |

## Verification
The phase-length check in the RTL assumes that the four count inputs hold steady while `busy` is 1. The bench changes the counts only between runs, after `done` has been seen. Requests are treated as pulses whose effect shows only in idle. The bench sends a start pulse only when the block is idle. It also injects a second request somewhere inside every run, and checks that the trace is unchanged. The sweep covers every mix of small counts, including zero, so the clamp rule and the shortest phases are reached.

// File: rtl/twi_rec_pkg.sv
package twi_rec_pkg;

    typedef enum logic [3:0] {
        PH_IDLE   = 4'd0,
        PH_SETUP1 = 4'd1,
        PH_HOLD1  = 4'd2,
        PH_ENTER  = 4'd3,
        PH_LOW    = 4'd4,
        PH_HIGH   = 4'd5,
        PH_SETUP2 = 4'd6,
        PH_HOLD2  = 4'd7,
        PH_FREE   = 4'd8
    } rec_phase_e;

endpackage

// File: rtl/twi_rec_len.sv
module twi_rec_len
    import twi_rec_pkg::*;
#(
    parameter int CW = 16
) (
    input  rec_phase_e    phase,
    input  logic [CW-1:0] cnt_low,
    input  logic [CW-1:0] cnt_high,
    input  logic [CW-1:0] cnt_edge,
    input  logic [CW-1:0] cnt_free,
    output logic [CW-1:0] len
);

    logic [CW-1:0] sel;

    always_comb begin
        case (phase)
            PH_SETUP1, PH_HOLD1, PH_ENTER,
            PH_SETUP2, PH_HOLD2: sel = cnt_edge;
            PH_LOW:              sel = cnt_low;
            PH_HIGH:             sel = cnt_high;
            PH_FREE:             sel = cnt_free;
            default:             sel = CW'(1);
        endcase
        // zero is clamped to one cycle
        len = (sel == '0) ? CW'(1) : sel;
    end

endmodule

// File: rtl/twi_rec_lines.sv
module twi_rec_lines
    import twi_rec_pkg::*;
(
    input  rec_phase_e phase,
    output logic       scl_pull,
    output logic       sda_pull
);

    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        case (phase)
            PH_HOLD1:  sda_pull = 1'b1;
            PH_ENTER: begin
                scl_pull = 1'b1;
                sda_pull = 1'b1;
            end
            PH_LOW:    scl_pull = 1'b1;
            PH_HOLD2:  sda_pull = 1'b1;
            default: begin
                scl_pull = 1'b0;
                sda_pull = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/twi_recover.sv
module twi_recover
    import twi_rec_pkg::*;
#(
    parameter int CW   = 16,
    parameter int NCLK = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic [CW-1:0] cnt_low,
    input  logic [CW-1:0] cnt_high,
    input  logic [CW-1:0] cnt_edge,
    input  logic [CW-1:0] cnt_free,
    output logic          scl_pull,
    output logic          sda_pull,
    output logic          busy,
    output logic          done
);

    localparam int NW = $clog2(NCLK + 1);

    typedef struct packed {
        rec_phase_e    phase;
        logic [CW-1:0] cnt;
        logic [NW-1:0] nclk;
        logic          done;
    } rec_state_t;

    rec_state_t s_q, s_d;
    logic [CW-1:0] len_w;
    logic          last_w;

    twi_rec_len #(.CW(CW)) u_len (
        .phase    (s_q.phase),
        .cnt_low  (cnt_low),
        .cnt_high (cnt_high),
        .cnt_edge (cnt_edge),
        .cnt_free (cnt_free),
        .len      (len_w)
    );

    twi_rec_lines u_lines (
        .phase    (s_q.phase),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull)
    );

    assign last_w = (s_q.cnt == (len_w - CW'(1)));
    assign busy   = (s_q.phase != PH_IDLE);
    assign done   = s_q.done;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.cnt  = s_q.cnt + CW'(1);
        if (s_q.phase == PH_IDLE) begin
            s_d.cnt = '0;
            if (start_req) begin
                s_d.phase = PH_SETUP1;
                s_d.nclk  = '0;
            end
        end else if (last_w) begin
            s_d.cnt = '0;
            case (s_q.phase)
                PH_SETUP1: s_d.phase = PH_HOLD1;
                PH_HOLD1:  s_d.phase = PH_ENTER;
                PH_ENTER:  s_d.phase = PH_LOW;
                PH_LOW:    s_d.phase = PH_HIGH;
                PH_HIGH: begin
                    if (s_q.nclk == NW'(NCLK - 1)) begin
                        s_d.phase = PH_SETUP2;
                    end else begin
                        s_d.phase = PH_LOW;
                        s_d.nclk  = s_q.nclk + NW'(1);
                    end
                end
                PH_SETUP2: s_d.phase = PH_HOLD2;
                PH_HOLD2:  s_d.phase = PH_FREE;
                PH_FREE: begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
                default:   s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.nclk  <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R6

    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R8

    AST_SDA_STILL_AT_SCL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_pull) || $fell(scl_pull)) |-> $stable(sda_pull)); // R9

    AST_PHASE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.cnt < len_w)); // R7

endmodule

// File: tb/sim_twi_recover.sv
`timescale 1ns/1ps
module sim_twi_recover;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_req = 1'b0;
    logic [CW-1:0] cnt_low = '0, cnt_high = '0, cnt_edge = '0, cnt_free = '0;
    logic          scl_pull, sda_pull, busy, done;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    twi_recover #(.CW(CW), .NCLK(9)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .cnt_low(cnt_low), .cnt_high(cnt_high), .cnt_edge(cnt_edge), .cnt_free(cnt_free),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int clamp1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    // expected {scl_pull, sda_pull, busy, done} at offset j after the accepting edge
    task automatic expect_at(input int j, input int lo, input int hi, input int su, input int bf,
                             output logic [3:0] v, output string tag);
        int p;
        int k;
        p = j;
        if (p < su) begin v = 4'b0010; tag = "R3"; return; end
        p -= su;
        if (p < su) begin v = 4'b0110; tag = "R3"; return; end
        p -= su;
        if (p < su) begin v = 4'b1110; tag = "R3"; return; end
        p -= su;
        if (p < 9 * (lo + hi)) begin
            k = p % (lo + hi);
            v = (k < lo) ? 4'b1010 : 4'b0010;
            tag = "R4";
            return;
        end
        p -= 9 * (lo + hi);
        if (p < su) begin v = 4'b0010; tag = "R5"; return; end
        p -= su;
        if (p < su) begin v = 4'b0110; tag = "R5"; return; end
        p -= su;
        if (p < bf) begin v = 4'b0010; tag = "R6"; return; end
        p -= bf;
        v = (p == 0) ? 4'b0001 : 4'b0000;
        tag = "R6";
    endtask

    task automatic run_cfg(input int rlo, input int rhi, input int rsu, input int rbf);
        int lo, hi, su, bf, total, inj;
        int starts, stops, rels, busy_cnt;
        logic [3:0] v, act, prev;
        string tag;
        lo = clamp1(rlo); hi = clamp1(rhi); su = clamp1(rsu); bf = clamp1(rbf);
        total = 5 * su + 9 * (lo + hi) + bf;
        inj = ((rlo * 7 + rhi * 3 + rsu * 5 + rbf) % (total - 2)) + 1;
        cnt_low = CW'(rlo); cnt_high = CW'(rhi); cnt_edge = CW'(rsu); cnt_free = CW'(rbf);
        starts = 0; stops = 0; rels = 0; busy_cnt = 0;
        @(negedge clk);
        prev = {scl_pull, sda_pull, busy, done};
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int j = 0; j <= total + 1; j++) begin
            if (j > 0) @(negedge clk);
            start_req = 1'b0;
            act = {scl_pull, sda_pull, busy, done};
            expect_at(j, lo, hi, su, bf, v, tag);
            chk(act === v, (j == inj + 1) ? "R8" : tag, int'(act), int'(v));
            if (act[3] != prev[3])
                chk(act[2] == prev[2], "R9", int'(act[2]), int'(prev[2]));
            if (!prev[3] && !act[3] && !prev[2] && act[2]) starts++;
            if (!prev[3] && !act[3] && prev[2] && !act[2]) stops++;
            if (prev[3] && !act[3]) rels++;
            if (act[1]) busy_cnt++;
            prev = act;
            if (j == inj) start_req = 1'b1;   // must be ignored: R8
        end
        start_req = 1'b0;
        chk(starts == 2, "R3", starts, 2);
        chk(stops == 1, "R5", stops, 1);
        chk(rels == 9, "R4", rels, 9);
        if (rlo == 0 || rhi == 0 || rsu == 0 || rbf == 0)
            chk(busy_cnt == total, "R7", busy_cnt, total);
        else
            chk(busy_cnt == total, "R2", busy_cnt, total);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({scl_pull, sda_pull, busy, done} === 4'b0000, "R1",
            int'({scl_pull, sda_pull, busy, done}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({scl_pull, sda_pull, busy, done} === 4'b0000, "R1",
            int'({scl_pull, sda_pull, busy, done}), 0);
        for (int a = 0; a <= 3; a++)
            for (int b = 0; b <= 2; b++)
                for (int c = 0; c <= 2; c++)
                    for (int d = 0; d <= 2; d += 2)
                        run_cfg(a, b, c, d);
        run_cfg(5, 3, 4, 7);
        report();
    end

endmodule